// File: doc/BRIEF.md
# Gigabit Half-Duplex Carrier Extension and Frame Burst Sequencer

This block sits on the transmit side of a half-duplex gigabit MAC. It sits between a byte-wide frame source and a byte-wide transmit interface. Each frame it takes in is sent behind a preamble, which is a run of `0x55` bytes ending in a single `0xD5` delimiter. The first frame of a transmission must hold the carrier for a full slot. If that frame is shorter than the slot, the block appends extension symbols until the slot is full. The carrier then stays on. The block sends interframe-gap symbols as extension, and a frame that is already waiting follows in the same burst at its natural length. Frames keep chaining until the burst has used up its byte budget. When the burst ends, the carrier drops and the line stays idle for at least one gap before a new burst may start.

The frame input is a valid/ready stream with start and end markers. Back-pressure works as follows:
- `in_ready` is high only while the block is in the data phase of a frame, and while it is idle and discarding stray beats that do not carry a start marker.
- A start-marked beat that arrives while the block is idle is held, with `in_ready` low, until the preamble has been sent.
- Once a frame has started, the source must present one byte every cycle until its end marker, and must never withdraw `in_valid` while it is waiting.

The transmit side has no back-pressure. It emits one symbol per clock on `tx_data`, `tx_en` and `tx_ext`, with one register stage of latency.

Burst accounting counts every symbol emitted since the first preamble byte of the burst. This includes preamble, data, extension and in-burst gap symbols.

Top module: `gbe_burst_tx`

## Requirements
- R1: After reset, `tx_en`, `tx_ext` and `in_ready` are low while `in_valid` is low.
- R2: Every frame is sent as PRE_BYTES symbols with `tx_en`=1, each `0x55` except the last, which is `0xD5`. These are followed at once by the frame bytes, in order, with `tx_en`=1. The first data byte appears the cycle after its beat is accepted.
- R3: When the first frame of a burst has fewer than SLOT_BYTES data bytes, extension symbols (`tx_ext`=1, `tx_en`=0, `tx_data`=`0x0F`) follow it. They continue until data bytes plus extension symbols equal SLOT_BYTES.
- R4: A first frame of SLOT_BYTES or more bytes receives no extension symbols.
- R5: When a frame (with any extension) ends and the burst count is at most BURST_BYTES, IFG_BYTES gap symbols follow with `tx_ext`=1 and `tx_en`=0 (data `0x0F`). If a frame is waiting by the last gap symbol, it starts with its preamble and is sent without extension.
- R6: When a frame ends with the burst count above BURST_BYTES, the carrier drops on the next symbol with no gap symbols. A frame in progress is always finished first.
- R7: When no start-marked beat is waiting at the last in-burst gap symbol, the carrier drops and the burst ends.
- R8: Between bursts the carrier (`tx_en` or `tx_ext`) stays low for at least IFG_BYTES cycles. The first frame of every new burst is extended again as in R3.
- R9: While idle, a valid beat without the start marker is consumed with `in_ready`=1 and produces no output. A start-marked beat waiting while idle sees `in_ready`=0.
- R10: `tx_en` and `tx_ext` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Source has a byte |
| in_ready | output | 1 | Byte accepted this cycle when high with `in_valid` |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| tx_data | output | 8 | Transmit symbol byte |
| tx_en | output | 1 | Symbol is preamble or frame data |
| tx_ext | output | 1 | Symbol is carrier extension or in-burst gap |

## Verification
Two of this block's decisions can fall in the same cycle. The first is the end of a frame. The second is the budget check that decides whether the burst may continue. The bench provokes this with three-frame bursts whose second frame length is swept across the point where the running count lands exactly on, just under and just over the budget. The expected symbol stream is computed arithmetically: it has gap symbols and a chained frame when the count is at most the limit, and an immediate carrier drop when it is above. A second pairing is checked in every burst: the last gap symbol coincides with the arrival of the next frame's start beat.

// File: rtl/gbx_pkg.sv
package gbx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_DATA,
    ST_EXT,
    ST_IFG,
    ST_GAP
  } gbx_state_e;

  typedef struct packed {
    logic       en;
    logic       ext;
    logic [7:0] data;
  } gbx_sym_t;

  localparam logic [7:0] PRE_BYTE = 8'h55;
  localparam logic [7:0] SFD_BYTE = 8'hD5;
  localparam logic [7:0] EXT_BYTE = 8'h0F;

endpackage

// File: rtl/gbx_budget.sv
module gbx_budget #(
  parameter int BURST_BYTES = 8192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic ok
);
  localparam int CW = $clog2(BURST_BYTES + 1) + 1;
  localparam logic [CW:0] LIM = (CW+1)'(BURST_BYTES);

  logic [CW-1:0] cnt;
  logic [CW:0]   with_cur;

  // count including the symbol emitted in the current cycle
  assign with_cur = {1'b0, cnt} + (CW+1)'(1);
  assign ok       = (with_cur <= LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (step && (cnt != '1)) begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/gbx_seq_ctrl.sv
module gbx_seq_ctrl
  import gbx_pkg::*;
#(
  parameter int SLOT_BYTES = 512,
  parameter int PRE_BYTES  = 8,
  parameter int IFG_BYTES  = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_sof,
  input  logic       in_eof,
  input  logic [7:0] in_data,
  input  logic       budget_ok,
  output logic       in_ready,
  output logic       budget_clear,
  output logic       budget_step,
  output gbx_sym_t   sym_next
);
  localparam int MAXPH = (PRE_BYTES > IFG_BYTES) ? PRE_BYTES : IFG_BYTES;
  localparam int PW    = $clog2(MAXPH + 1);
  localparam int SW    = $clog2(SLOT_BYTES + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(PRE_BYTES - 1);
  localparam logic [PW-1:0] IFG_LAST = PW'(IFG_BYTES - 1);
  localparam logic [SW:0]   SLOT_V   = (SW+1)'(SLOT_BYTES);
  localparam logic [SW-1:0] SLOT_SAT = SW'(SLOT_BYTES);

  gbx_state_e    state, state_n;
  logic [PW-1:0] phase;
  logic [SW-1:0] slot_cnt;
  logic          first_q;
  logic          slot_done;

  // true when the symbol sent this cycle completes the slot
  assign slot_done = (({1'b0, slot_cnt} + (SW+1)'(1)) >= SLOT_V);

  always_comb begin
    state_n      = state;
    sym_next     = '0;
    in_ready     = 1'b0;
    budget_clear = 1'b0;
    budget_step  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (in_valid) begin
          if (in_sof) begin
            state_n      = ST_PRE;
            budget_clear = 1'b1;
          end else begin
            in_ready = 1'b1;
          end
        end
      end
      ST_PRE: begin
        sym_next.en   = 1'b1;
        sym_next.data = (phase == PRE_LAST) ? SFD_BYTE : PRE_BYTE;
        budget_step   = 1'b1;
        if (phase == PRE_LAST) state_n = ST_DATA;
      end
      ST_DATA: begin
        in_ready = 1'b1;
        if (in_valid) begin
          sym_next.en   = 1'b1;
          sym_next.data = in_data;
          budget_step   = 1'b1;
          if (in_eof) begin
            if (first_q && !slot_done) state_n = ST_EXT;
            else if (budget_ok)        state_n = ST_IFG;
            else                       state_n = ST_GAP;
          end
        end
      end
      ST_EXT: begin
        sym_next.ext  = 1'b1;
        sym_next.data = EXT_BYTE;
        budget_step   = 1'b1;
        if (slot_done) state_n = budget_ok ? ST_IFG : ST_GAP;
      end
      ST_IFG: begin
        sym_next.ext  = 1'b1;
        sym_next.data = EXT_BYTE;
        budget_step   = 1'b1;
        if (phase == IFG_LAST) state_n = (in_valid && in_sof) ? ST_PRE : ST_GAP;
      end
      ST_GAP: begin
        if (phase == IFG_LAST) state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      phase    <= '0;
      slot_cnt <= '0;
      first_q  <= 1'b0;
    end else begin
      state <= state_n;
      if ((state_n != state) || (state == ST_IDLE)) phase <= '0;
      else                                          phase <= phase + PW'(1);

      if ((state == ST_IDLE) || (state == ST_IFG)) begin
        slot_cnt <= '0;
      end else if (((state == ST_DATA) && in_valid) || (state == ST_EXT)) begin
        if (slot_cnt != SLOT_SAT) slot_cnt <= slot_cnt + SW'(1);
      end

      if ((state == ST_IDLE) && (state_n == ST_PRE))     first_q <= 1'b1;
      else if ((state == ST_IFG) && (state_n == ST_PRE)) first_q <= 1'b0;
    end
  end
endmodule

// File: rtl/gbx_tx_reg.sv
module gbx_tx_reg
  import gbx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  gbx_sym_t   sym_in,
  output logic [7:0] tx_data,
  output logic       tx_en,
  output logic       tx_ext
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_data <= '0;
      tx_en   <= 1'b0;
      tx_ext  <= 1'b0;
    end else begin
      tx_data <= sym_in.data;
      tx_en   <= sym_in.en;
      tx_ext  <= sym_in.ext;
    end
  end
endmodule

// File: rtl/gbe_burst_tx.sv
module gbe_burst_tx
  import gbx_pkg::*;
#(
  parameter int SLOT_BYTES  = 512,
  parameter int PRE_BYTES   = 8,
  parameter int IFG_BYTES   = 12,
  parameter int BURST_BYTES = 8192
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_sof,
  input  logic       in_eof,
  output logic [7:0] tx_data,
  output logic       tx_en,
  output logic       tx_ext
);
  logic     budget_ok, budget_clear, budget_step;
  gbx_sym_t sym_next;

  gbx_seq_ctrl #(
    .SLOT_BYTES(SLOT_BYTES),
    .PRE_BYTES (PRE_BYTES),
    .IFG_BYTES (IFG_BYTES)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_sof      (in_sof),
    .in_eof      (in_eof),
    .in_data     (in_data),
    .budget_ok   (budget_ok),
    .in_ready    (in_ready),
    .budget_clear(budget_clear),
    .budget_step (budget_step),
    .sym_next    (sym_next)
  );

  gbx_budget #(
    .BURST_BYTES(BURST_BYTES)
  ) u_budget (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(budget_clear),
    .step (budget_step),
    .ok   (budget_ok)
  );

  gbx_tx_reg u_txreg (
    .clk    (clk),
    .rst_n  (rst_n),
    .sym_in (sym_next),
    .tx_data(tx_data),
    .tx_en  (tx_en),
    .tx_ext (tx_ext)
  );
endmodule

// File: rtl/gbe_burst_tx_chk.sv
module gbe_burst_tx_chk #(
  parameter int SLOT_BYTES  = 512,
  parameter int PRE_BYTES   = 8,
  parameter int IFG_BYTES   = 12,
  parameter int BURST_BYTES = 8192
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_data,
  input logic       in_sof,
  input logic [7:0] tx_data,
  input logic       tx_en,
  input logic       tx_ext
);
  logic        carrier;
  int unsigned on_len;
  int unsigned idle_len;

  assign carrier = tx_en | tx_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_len   <= 0;
      idle_len <= IFG_BYTES;
    end else if (carrier) begin
      if (on_len < 32'h00FF_FFFF) on_len <= on_len + 1;
      idle_len <= 0;
    end else begin
      on_len <= 0;
      if (idle_len < 32'h00FF_FFFF) idle_len <= idle_len + 1;
    end
  end

  // R10: data and extension are mutually exclusive
  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_en && tx_ext));

  // R2: an accepted start beat shows up as data on the next cycle
  p_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_sof) |=> (tx_en && !tx_ext && (tx_data == $past(in_data))));

  // R3: every carrier run covers preamble plus a full slot
  p_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(carrier) |-> (on_len >= PRE_BYTES + SLOT_BYTES));

  // R6: a chained frame only starts if the budget held at the gap start
  p_budget_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && $past(tx_ext)) |-> (on_len <= BURST_BYTES + IFG_BYTES));

  // R8: idle gap between bursts
  p_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(carrier) |-> (idle_len >= IFG_BYTES));
endmodule

bind gbe_burst_tx gbe_burst_tx_chk #(
  .SLOT_BYTES (SLOT_BYTES),
  .PRE_BYTES  (PRE_BYTES),
  .IFG_BYTES  (IFG_BYTES),
  .BURST_BYTES(BURST_BYTES)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .in_data (in_data),
  .in_sof  (in_sof),
  .tx_data (tx_data),
  .tx_en   (tx_en),
  .tx_ext  (tx_ext)
);

// File: tb/gbe_burst_tx_bench.sv
`timescale 1ns/1ps
module gbe_burst_tx_bench;
  localparam int SLOT  = 16;
  localparam int PRE   = 2;
  localparam int IFG   = 3;
  localparam int LIMIT = 64;
  localparam logic [9:0] SENT = 10'h3FF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, tx_en, tx_ext;
  logic [7:0] tx_data;

  gbe_burst_tx #(
    .SLOT_BYTES(SLOT), .PRE_BYTES(PRE), .IFG_BYTES(IFG), .BURST_BYTES(LIMIT)
  ) u_gbe_burst_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .tx_data(tx_data), .tx_en(tx_en), .tx_ext(tx_ext)
  );

  always #10 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  logic [9:0] exp_q [0:1023];
  string      exp_tag [0:1023];
  int exp_len, idx, idle_run;
  string hint;
  int flen [0:7];
  int nfr, junk;
  bit mon_on = 0, prev_car = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  function automatic logic [7:0] byte_of(input int f, input int b);
    return 8'((f * 29) + (b * 7) + 3);
  endfunction

  task automatic push(input logic [9:0] s, input string t);
    exp_q[exp_len] = s;
    exp_tag[exp_len] = (hint != "") ? hint : t;
    hint = "";
    exp_len++;
  endtask

  task automatic push_frame(input int f, input bit ext_ok, inout int t);
    for (int p = 0; p < PRE; p++) begin
      push({2'b10, (p == PRE-1) ? 8'hD5 : 8'h55}, "R2"); t++;
    end
    for (int b = 0; b < flen[f]; b++) begin
      push({2'b10, byte_of(f, b)}, "R2"); t++;
    end
    if (ext_ok) begin
      for (int e = flen[f]; e < SLOT; e++) begin
        push({2'b01, 8'h0F}, "R3"); t++;
      end
      if (flen[f] >= SLOT) hint = "R4";
    end
  endtask

  task automatic build_expected();
    int i, t;
    exp_len = 0; hint = ""; i = 0;
    while (i < nfr) begin
      t = 0;
      push_frame(i, 1'b1, t);
      while (1) begin
        if (t <= LIMIT) begin
          for (int g = 0; g < IFG; g++) push({2'b01, 8'h0F}, "R5");
          t += IFG;
          if (i + 1 < nfr) begin
            i++;
            push_frame(i, 1'b0, t);
          end else begin
            push(SENT, "R7"); i++; break;
          end
        end else begin
          push(SENT, "R6"); i++; break;
        end
      end
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (tx_en || tx_ext) begin
        chk(!(tx_en && tx_ext), "R10", "en and ext together", {tx_en, tx_ext}, 2'b00);
        if (!prev_car) chk(idle_run >= IFG, "R8", "idle cycles before carrier", idle_run, IFG);
        if (idx < exp_len) chk({tx_en, tx_ext, tx_data} == exp_q[idx], exp_tag[idx],
                               "symbol", {tx_en, tx_ext, tx_data}, exp_q[idx]);
        else chk(1'b0, "R7", "symbol after expected end", {tx_en, tx_ext, tx_data}, 0);
        idx++;
        idle_run = 0;
      end else begin
        if (prev_car) begin
          if (idx < exp_len) chk(exp_q[idx] == SENT, exp_tag[idx], "carrier dropped early", 0, exp_q[idx]);
          else chk(1'b0, "R7", "extra carrier drop", 0, 0);
          idx++;
        end
        idle_run++;
      end
      prev_car = tx_en || tx_ext;
    end
  end

  task automatic beat(input logic sof, input logic eof, input logic [7:0] d,
                      input int rdy_chk);
    in_valid = 1'b1; in_sof = sof; in_eof = eof; in_data = d;
    @(negedge clk);
    if (rdy_chk == 1) chk(in_ready == 1'b1, "R9", "stray beat ready while idle", in_ready, 1);
    if (rdy_chk == 2) chk(in_ready == 1'b0, "R9", "start beat held while idle", in_ready, 0);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic run_case();
    build_expected();
    idx = 0; prev_car = 0; idle_run = 1000; mon_on = 1;
    for (int j = 0; j < junk; j++) beat(1'b0, 1'b0, 8'hA0 + 8'(j), 1);
    for (int f = 0; f < nfr; f++)
      for (int b = 0; b < flen[f]; b++)
        beat(b == 0, b == flen[f] - 1, byte_of(f, b), (f == 0 && b == 0) ? 2 : 0);
    for (int k = 0; k < 4000 && idx < exp_len; k++) @(posedge clk);
    repeat (IFG + 4) @(posedge clk);
    mon_on = 0;
    chk(idx == exp_len, "R5", "symbols observed in case", idx, exp_len);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog R1..: run hung actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(tx_en == 1'b0, "R1", "tx_en after reset", tx_en, 0);
    chk(tx_ext == 1'b0, "R1", "tx_ext after reset", tx_ext, 0);
    chk(in_ready == 1'b0, "R1", "in_ready after reset", in_ready, 0);
    @(posedge clk); #1;

    // single frames across the slot boundary (R3, R4, R7, R9)
    for (int L = 1; L <= 20; L++) begin
      nfr = 1; flen[0] = L; junk = L % 3;
      run_case();
    end
    // two-frame bursts: only the first is extended (R5)
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++) begin
        nfr = 2; junk = 0;
        flen[0] = (a == 0) ? 4 : (a == 1) ? 16 : 19;
        flen[1] = 1 + 4 * b;
        run_case();
      end
    // budget boundary sweep: frame end meets budget check (R6, R8)
    for (int L = 36; L <= 44; L++) begin
      nfr = 3; junk = 0; flen[0] = 16; flen[1] = L; flen[2] = 3;
      run_case();
    end
    // long trains split into several bursts (R6, R8)
    nfr = 5; junk = 0;
    for (int f = 0; f < 5; f++) flen[f] = 12;
    run_case();
    nfr = 4; junk = 1;
    for (int f = 0; f < 4; f++) flen[f] = 30;
    run_case();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule